// File: doc/BRIEF.md
# Dual-Reference Clock Supervisor

This block is the digital supervisor of a clock module that has two nominal 19.44 MHz reference inputs. It runs on a free-running local clock. Each reference is brought into that clock domain and its rising edges are counted over a fixed window of local-clock cycles. A reference with no edges in a window counts as lost. A reference whose edge count falls outside a ppm-derived band also counts as lost. From the health of both references, the select input, the force-free-run input and the lock indication from the loop, the block decides the operating mode. It then drives the free-run status, the alarm and the locked-to-A and locked-to-B flags.

The selected reference clock is routed to the loop through `ref_out`. In free run, `ref_out` is held low. If the selected reference dies while the other is healthy, the block does not switch to the other reference on its own. It reports an unstable state with the alarm raised, and leaves the choice of reference to the system. After every change of the select input, the loss-of-lock part of the alarm is blanked for a programmable number of cycles. This gives the loop time to pull in without a false alarm. A separate output-enable follows the disable input and the reset.

Top module: `refsel_alarm_ctrl`

## Requirements
- R1: `sel_ab` = 0 selects reference A and `sel_ab` = 1 selects reference B. With the selected reference healthy, `force_fr` = 0 and `pll_lock` = 1, `lock_a` (for A) or `lock_b` (for B) is 1, and `fr_status` and `alarm` are 0.
- R2: `force_fr` = 1 gives `fr_status` = 1, `alarm` = 0 and `lock_a` = `lock_b` = 0, whatever the reference health, the select input and `pll_lock` are.
- R3: With `force_fr` = 0 and both references lost, the block is in free run: `fr_status` = 1, `alarm` = 1, `lock_a` = `lock_b` = 0.
- R4: With the selected reference healthy and `pll_lock` = 1, `alarm` stays 0 even when the other reference is lost or out of range.
- R5: With `force_fr` = 0, the selected reference lost and the other healthy, the state is unstable: `alarm` = 1, `fr_status` = 0, `lock_a` = `lock_b` = 0. The selection is not changed.
- R6: While tracking a healthy reference, `pll_lock` = 0 raises `alarm` once no blanking interval is running. The alarm is the OR of loss of reference and loss of lock.
- R7: For QUAL_CYCLES local-clock cycles after any change of `sel_ab`, loss of lock does not raise `alarm`. When that interval ends, a persisting loss of lock raises it.
- R8: While `reset` is 1, the registered outputs take the default state: `fr_status` = 1, `alarm` = 0, `lock_a` = `lock_b` = 0, `out_en` = 0.
- R9: `out_en` is the inverse of `out_disable`, one cycle late, and is 0 during reset.
- R10: A reference with no rising edge during a whole count window is treated as lost.
- R11: A reference whose edge count in a window lies outside NOM_EDGES ± (NOM_EDGES·PPM_TOL/10^6 + 1) is treated as lost. With the bench settings, a period of 8 local cycles is in range, and periods of 7 and 9 are out of range.
- R12: `ref_out` carries reference A when tracking A and reference B when tracking B, and is held low in free run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| reset | input | 1 | Synchronous reset, active high |
| ref_a | input | 1 | Reference clock A, asynchronous |
| ref_b | input | 1 | Reference clock B, asynchronous |
| sel_ab | input | 1 | Reference select, 0 = A, 1 = B |
| force_fr | input | 1 | Force free run, active high |
| out_disable | input | 1 | Output disable, active high |
| pll_lock | input | 1 | Lock indication from the loop, 1 = locked |
| ref_out | output | 1 | Selected reference routed to the loop |
| fr_status | output | 1 | Free-run indication |
| alarm | output | 1 | Loss of reference or loss of lock, active high |
| lock_a | output | 1 | Tracking reference A |
| lock_b | output | 1 | Tracking reference B |
| out_en | output | 1 | Output enable for the oscillator drivers |

## Verification
The assertions check the mode decisions on every cycle, one cycle after their inputs. These cover the force and reset defaults, free run with alarm when both references are lost, the unstable state, silence during blanking, the single active mode flag, the output-enable delay, and the loss flag after an empty window. The edge counting itself is shown only by the bench scenarios: stopped, fast and slow reference clocks that must be classified correctly over several windows. The same holds for the end of the blanking interval and for the routing of the live reference clock to `ref_out`.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_TRACK_A  = 2'd1,
    MODE_TRACK_B  = 2'd2,
    MODE_UNSTABLE = 2'd3
  } refsel_mode_e;

  function automatic int unsigned tol_edges(input int unsigned nom, input int unsigned ppm);
    return (nom * ppm) / 1000000 + 1;
  endfunction
endpackage

// File: rtl/refsel_sync_edge.sv
module refsel_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic reset,
  input  logic async_in,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (reset) begin
      sync_q     <= '0;
      last_q     <= 1'b0;
      rise_pulse <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], async_in};
      last_q     <= sync_q[SYNC_STAGES-1];
      rise_pulse <= sync_q[SYNC_STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/refsel_freq_mon.sv
module refsel_freq_mon #(
  parameter int WIN_CYCLES = 256,
  parameter int NOM_EDGES  = 32,
  parameter int PPM_TOL    = 25
) (
  input  logic clk,
  input  logic reset,
  input  logic edge_pulse,
  output logic ref_good
);
  import refsel_pkg::*;
  localparam int TOL    = int'(tol_edges(NOM_EDGES, PPM_TOL));
  localparam int LO_RAW = NOM_EDGES - TOL;
  localparam int LO_B   = (LO_RAW < 1) ? 1 : LO_RAW;
  localparam int HI_B   = NOM_EDGES + TOL;
  localparam int WW     = $clog2(WIN_CYCLES + 1);
  localparam int EW     = $clog2(WIN_CYCLES + 2);

  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [EW-1:0] edge_total;
  logic          win_end;

  assign win_end    = (win_cnt == WW'(WIN_CYCLES - 1));
  assign edge_total = edge_cnt + EW'(edge_pulse);

  always_ff @(posedge clk) begin
    if (reset) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      ref_good <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      ref_good <= (edge_total >= EW'(LO_B)) && (edge_total <= EW'(HI_B));
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= edge_total;
    end
  end

  // R10: an empty window must mark the reference lost
  a_r10_empty_window_lost: assert property (@(posedge clk) disable iff (reset)
    (win_end && edge_cnt == '0 && !edge_pulse) |=> !ref_good);
endmodule

// File: rtl/refsel_mode_fsm.sv
module refsel_mode_fsm #(
  parameter int QUAL_CYCLES = 50000000
) (
  input  logic clk,
  input  logic reset,
  input  logic sel_ab,
  input  logic force_fr,
  input  logic good_a,
  input  logic good_b,
  input  logic pll_lock,
  output logic route_en,
  output logic route_b,
  output logic fr_status,
  output logic alarm,
  output logic lock_a,
  output logic lock_b
);
  import refsel_pkg::*;
  localparam int QW = $clog2(QUAL_CYCLES + 1);

  logic          sel_prev;
  logic [QW-1:0] qual_cnt;
  logic          sel_change;
  logic          blank;
  logic          sel_good;
  logic          oth_good;
  refsel_mode_e  mode_n;
  logic          alarm_n;

  assign sel_change = (sel_ab != sel_prev);
  assign blank      = sel_change || (qual_cnt != '0);
  assign sel_good   = sel_ab ? good_b : good_a;
  assign oth_good   = sel_ab ? good_a : good_b;

  always_comb begin
    mode_n  = MODE_FREE;
    alarm_n = 1'b0;
    if (force_fr) begin
      mode_n  = MODE_FREE;
      alarm_n = 1'b0;
    end else if (sel_good) begin
      mode_n  = sel_ab ? MODE_TRACK_B : MODE_TRACK_A;
      alarm_n = ~pll_lock & ~blank;
    end else if (oth_good) begin
      mode_n  = MODE_UNSTABLE;
      alarm_n = 1'b1;
    end else begin
      mode_n  = MODE_FREE;
      alarm_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      sel_prev  <= 1'b0;
      qual_cnt  <= '0;
      route_en  <= 1'b0;
      route_b   <= 1'b0;
      fr_status <= 1'b1;
      alarm     <= 1'b0;
      lock_a    <= 1'b0;
      lock_b    <= 1'b0;
    end else begin
      sel_prev  <= sel_ab;
      if (sel_change)          qual_cnt <= QW'(QUAL_CYCLES);
      else if (qual_cnt != '0) qual_cnt <= qual_cnt - 1'b1;
      route_en  <= (mode_n != MODE_FREE);
      route_b   <= sel_ab;
      fr_status <= (mode_n == MODE_FREE);
      alarm     <= alarm_n;
      lock_a    <= (mode_n == MODE_TRACK_A);
      lock_b    <= (mode_n == MODE_TRACK_B);
    end
  end

  // R8: reset gives the default free-run state
  a_r8_reset_default: assert property (@(posedge clk)
    reset |=> (fr_status && !alarm && !lock_a && !lock_b));
  // R2: forcing free run overrides everything
  a_r2_force_free: assert property (@(posedge clk) disable iff (reset)
    force_fr |=> (fr_status && !alarm && !lock_a && !lock_b));
  // R3: both references lost leads to free run with alarm
  a_r3_both_lost: assert property (@(posedge clk) disable iff (reset)
    (!force_fr && !good_a && !good_b) |=> (fr_status && alarm));
  // R5: unstable state, no automatic failover
  a_r5_unstable: assert property (@(posedge clk) disable iff (reset)
    (!force_fr && !sel_good && oth_good) |=> (alarm && !fr_status && !lock_a && !lock_b));
  // R7: blanking keeps alarm silent while tracking a healthy reference
  a_r7_blank_quiet: assert property (@(posedge clk) disable iff (reset)
    (!force_fr && sel_good && blank) |=> !alarm);
  // R1: at most one mode flag at a time
  a_r1_one_mode: assert property (@(posedge clk) disable iff (reset)
    $onehot0({fr_status, lock_a, lock_b}));
endmodule

// File: rtl/refsel_alarm_ctrl.sv
module refsel_alarm_ctrl #(
  parameter int WIN_CYCLES  = 256,
  parameter int NOM_EDGES   = 32,
  parameter int PPM_TOL     = 25,
  parameter int QUAL_CYCLES = 50000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic reset,
  input  logic ref_a,
  input  logic ref_b,
  input  logic sel_ab,
  input  logic force_fr,
  input  logic out_disable,
  input  logic pll_lock,
  output logic ref_out,
  output logic fr_status,
  output logic alarm,
  output logic lock_a,
  output logic lock_b,
  output logic out_en
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_in;
  logic [NREF-1:0] rise;
  logic [NREF-1:0] good;
  logic            route_en;
  logic            route_b;

  assign ref_in = {ref_b, ref_a};

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    refsel_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .reset(reset), .async_in(ref_in[i]), .rise_pulse(rise[i])
    );
    refsel_freq_mon #(.WIN_CYCLES(WIN_CYCLES), .NOM_EDGES(NOM_EDGES), .PPM_TOL(PPM_TOL)) u_mon (
      .clk(clk), .reset(reset), .edge_pulse(rise[i]), .ref_good(good[i])
    );
  end

  refsel_mode_fsm #(.QUAL_CYCLES(QUAL_CYCLES)) u_fsm (
    .clk(clk), .reset(reset), .sel_ab(sel_ab), .force_fr(force_fr),
    .good_a(good[0]), .good_b(good[1]), .pll_lock(pll_lock),
    .route_en(route_en), .route_b(route_b), .fr_status(fr_status),
    .alarm(alarm), .lock_a(lock_a), .lock_b(lock_b)
  );

  assign ref_out = route_en & (route_b ? ref_b : ref_a);

  always_ff @(posedge clk) begin
    if (reset) out_en <= 1'b0;
    else       out_en <= ~out_disable;
  end

  // R9: disable input turns the enable off on the next cycle
  a_r9_disable_off: assert property (@(posedge clk) disable iff (reset)
    out_disable |=> !out_en);
endmodule

// File: tb/refsel_alarm_ctrl_tb_top.sv
module refsel_alarm_ctrl_tb_top;
  localparam int WIN    = 256;
  localparam int QUAL   = 64;
  localparam int SETTLE = 3 * WIN + 32;
  localparam int NVEC   = 13;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic sel_ab = 1'b0, force_fr = 1'b0, out_disable = 1'b0, pll_lock = 1'b1;
  logic ref_out, fr_status, alarm, lock_a, lock_b, out_en;
  int   per_a = 0, per_b = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  refsel_alarm_ctrl #(.WIN_CYCLES(WIN), .NOM_EDGES(32), .PPM_TOL(25), .QUAL_CYCLES(QUAL)) dut_i (
    .clk(clk), .reset(reset), .ref_a(ref_a), .ref_b(ref_b), .sel_ab(sel_ab),
    .force_fr(force_fr), .out_disable(out_disable), .pll_lock(pll_lock),
    .ref_out(ref_out), .fr_status(fr_status), .alarm(alarm),
    .lock_a(lock_a), .lock_b(lock_b), .out_en(out_en)
  );

  // reference generators, period in local-clock cycles, 0 = stopped
  always begin
    if (per_a == 0) begin ref_a = 1'b0; @(negedge clk); end
    else begin
      ref_a = 1'b1; repeat (per_a / 2) @(negedge clk);
      ref_a = 1'b0; repeat (per_a - per_a / 2) @(negedge clk);
    end
  end
  always begin
    if (per_b == 0) begin ref_b = 1'b0; @(negedge clk); end
    else begin
      ref_b = 1'b1; repeat (per_b / 2) @(negedge clk);
      ref_b = 1'b0; repeat (per_b - per_b / 2) @(negedge clk);
    end
  end

  function automatic int per_of(input logic [1:0] code);
    case (code)
      2'd1:    return 8;  // nominal
      2'd2:    return 7;  // fast
      2'd3:    return 9;  // slow
      default: return 0;  // stopped
    endcase
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {fr,alarm,la,lb,en} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {force, sel, a_code, b_code, pll_lock, fr, alarm, lock_a, lock_b}
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_0_01_01_1_0010, // R1 track A
    11'b0_1_01_01_1_0001, // R1 track B
    11'b0_0_01_00_1_0010, // R4 B absent, A fine
    11'b0_1_00_01_1_0001, // R4 A absent, B fine
    11'b0_0_00_01_1_0100, // R5 A selected and dead
    11'b0_1_01_00_1_0100, // R5 B selected and dead
    11'b0_0_00_00_1_1100, // R3 both lost
    11'b1_0_01_01_1_1000, // R2 force with good refs
    11'b1_1_00_00_0_1000, // R2 force with no refs
    11'b0_0_10_01_1_0100, // R11 A fast
    11'b0_1_01_11_1_0100, // R11 B slow
    11'b0_0_01_01_0_0110, // R6 loss of lock
    11'b0_1_11_01_1_0001  // R4 other slow, selected fine
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int mism;
    // R8 reset state
    repeat (4) @(negedge clk);
    chk("R8", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b10000);
    reset = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b11001);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      force_fr = VEC[v][10];
      sel_ab   = VEC[v][9];
      per_a    = per_of(VEC[v][8:7]);
      per_b    = per_of(VEC[v][6:5]);
      pll_lock = VEC[v][4];
      repeat (SETTLE) @(negedge clk);
      chk($sformatf("R1-table row %0d (R2/R3/R4/R5/R6/R11)", v),
          {fr_status, alarm, lock_a, lock_b, out_en}, {VEC[v][3:0], 1'b1});
    end

    // R10 stopped reference after tracking: selected A stops, B still good
    force_fr = 1'b0; sel_ab = 1'b0; per_a = 8; per_b = 8; pll_lock = 1'b1;
    repeat (SETTLE) @(negedge clk);
    per_a = 0;
    repeat (SETTLE) @(negedge clk);
    chk("R10", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b01001);

    // R12 routing: tracking A
    per_a = 8;
    repeat (SETTLE) @(negedge clk);
    mism = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (ref_out !== ref_a) mism++; end
    chk("R12 route A", {4'b0, mism != 0}, 5'b0);
    sel_ab = 1'b1;
    repeat (8) @(negedge clk);
    mism = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (ref_out !== ref_b) mism++; end
    chk("R12 route B", {4'b0, mism != 0}, 5'b0);
    force_fr = 1'b1;
    repeat (4) @(negedge clk);
    mism = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (ref_out !== 1'b0) mism++; end
    chk("R12 free run low", {4'b0, mism != 0}, 5'b0);
    force_fr = 1'b0;

    // R7 blanking after select change, with loss of lock
    sel_ab = 1'b0; pll_lock = 1'b0;
    repeat (QUAL + 40) @(negedge clk);
    chk("R6 lol before switch", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b01101);
    sel_ab = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 blanked", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b00011);
    repeat (QUAL + 10) @(negedge clk);
    chk("R7 blank ends", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b01011);
    pll_lock = 1'b1;

    // R9 output disable
    out_disable = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 disabled", {4'b0, out_en}, 5'b00000);
    out_disable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 enabled", {4'b0, out_en}, 5'b00001);

    // R8 reset in the middle of tracking
    reset = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 mid-run", {fr_status, alarm, lock_a, lock_b, out_en}, 5'b10000);
    reset = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule